// File: doc/BRIEF.md
# I/Q Feed-Forward Table Player

This block adds a precomputed correction to the output of an RF control loop. The correction repeats with every RF pulse. A host processor fills a table of signed 8-bit in-phase and quadrature values, for example with values from an adaptive algorithm that cancels beam loading. Each accepted pulse start makes the block step through the table from the first entry. Each entry is held for a fixed number of loop-clock cycles, 8 or 16, which at a 40 MHz loop clock is 200 ns or 400 ns. The current pair is presented sign-extended to the loop's wide datapath, so it can be added straight to the controller output.

The table has two banks. The bank being played is never written. Host writes land in the other bank, the load bank. The first accepted pulse start after any write swaps the two banks, so a new table takes effect from the start of a pulse and never part-way through one. The host is expected to rewrite the whole table before each swap, because the bank it writes into after a swap still holds the table from two loads earlier. The output is zero when feed-forward is disabled, when the RF gate is low and once the last entry has been played.

Top module: `ff_playback`

## Requirements
- R1: During and after a synchronous active-low reset, with no accepted pulse start since, both outputs are zero and the load bank is bank 1.
- R2: A write stores an 8-bit I and an 8-bit Q value at a 12-bit table address (4096 entries by default) in the load bank; writes alone never change the outputs.
- R3: A pulse start is accepted when `pulse_start` and `rf_gate` are both high at a clock edge; entry 0 is presented from the second rising edge after the accepting edge.
- R4: Each entry is held for 8 cycles when `gran_sel` is 0 and for 16 cycles when it is 1; `gran_sel` is sampled only at the accepting edge.
- R5: Table values are two's complement; the outputs carry them sign-extended to 16 bits (8'h80 gives 16'hFF80, 8'h7F gives 16'h007F).
- R6: After the last entry has been held for its full time, both outputs are zero until the next accepted start.
- R7: With `ff_enable` low, the outputs are zero from the next edge on, and the stepping continues, so re-enabling resumes at the entry that the time since start implies.
- R8: With `rf_gate` low, playback stops, the outputs go to zero from the next edge on, and `pulse_start` is ignored; raising the gate again does not resume playback without a new start.
- R9: An accepted start swaps the played bank and the load bank if at least one write happened since the previous swap; otherwise the same bank plays again. Writes made during a pulse do not alter that pulse.
- R10: An accepted start during playback restarts at entry 0 with a fresh hold count.
- R11: A write in the same cycle as an accepted start goes into the bank that this start begins to play, and it counts as a reason to swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe into the load bank |
| wr_addr | input | ADDR_W (12) | Table address to write |
| wr_i | input | IQ_W (8) | In-phase value to write, two's complement |
| wr_q | input | IQ_W (8) | Quadrature value to write, two's complement |
| rf_gate | input | 1 | High while the RF pulse window is open |
| pulse_start | input | 1 | One-cycle strobe that starts playback |
| ff_enable | input | 1 | Feed-forward on when high |
| gran_sel | input | 1 | Hold time per entry: 0 gives 8 cycles, 1 gives 16 |
| ff_i | output | OUT_W (16) | Sign-extended in-phase correction |
| ff_q | output | OUT_W (16) | Sign-extended quadrature correction |

## Verification
A host write and an accepted pulse start can fall in the same clock cycle, and that cycle decides both which bank is written and whether the banks swap. The bench drives a write to entry 0 together with a pulse start and expects that new value on the outputs two edges later, together with the older values for the other entries of the same bank. A write stream also runs while a pulse is playing; the outputs must keep the old table for the rest of that pulse and show the new one only after the next start. A behavioural model tracks both banks, the swap flag and the hold count, and its result is compared with the outputs on every cycle.

// File: rtl/ff_pkg.sv
// ff_pkg: shared constants and types of the feed-forward player.
// Assumes nothing; holds default widths, hold lengths and the granularity code.
package ff_pkg;
    localparam int unsigned FF_IQ_W    = 8;
    localparam int unsigned FF_OUT_W   = 16;
    localparam int unsigned FF_ADDR_W  = 12;
    localparam int unsigned FF_SHORT_C = 8;
    localparam int unsigned FF_LONG_C  = 16;

    // Hold time code on gran_sel.
    typedef enum logic {
        GRAN_SHORT = 1'b0,
        GRAN_LONG  = 1'b1
    } ff_gran_e;
endpackage

// File: rtl/ff_iq_ram.sv
// ff_iq_ram: two-bank table of I/Q pairs, one write port and one registered read port.
// Assumes the writer always targets the bank that is not being played, so a
// read and a write never hit the same word.
module ff_iq_ram #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned IQ_W   = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [IQ_W-1:0]   wr_i,
    input  logic [IQ_W-1:0]   wr_q,
    input  logic              play_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [IQ_W-1:0]   rd_i,
    output logic [IQ_W-1:0]   rd_q
);
    localparam int unsigned WORDS = 2 * (1 << ADDR_W);
    localparam int unsigned WORD_W = 2 * IQ_W;

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] rd_word;

    // Host write: always into the load bank, the one not being played.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{~play_bank, wr_addr}] <= {wr_i, wr_q};
        end
    end

    // Registered read of the current entry from the played bank.
    always_ff @(posedge clk) begin
        rd_word <= mem[{play_bank, rd_addr}];
    end

    assign rd_i = rd_word[WORD_W-1:IQ_W];
    assign rd_q = rd_word[IQ_W-1:0];
endmodule

// File: rtl/ff_step_timer.sv
// ff_step_timer: prescaler that sets how long each table entry is held.
// Assumes restart is a one-cycle strobe; the hold length is latched on restart,
// so gran_sel may change freely during a pulse.
module ff_step_timer
    import ff_pkg::*;
#(
    parameter int unsigned SHORT_C = 8,
    parameter int unsigned LONG_C  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic gran_sel,
    output logic step
);
    localparam int unsigned CNT_W = (LONG_C > 1) ? $clog2(LONG_C) : 1;
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_C - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_C - 1);

    logic [CNT_W-1:0] pre_q;
    logic             long_q;
    logic [CNT_W-1:0] last;

    // Terminal count picked by the granularity latched at the last start.
    assign last = long_q ? LONG_LAST : SHORT_LAST;
    assign step = run && (pre_q == last);

    // Prescaler: cleared on restart, wraps at the terminal count while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            long_q <= 1'b0;
        end else if (restart) begin
            pre_q  <= '0;
            long_q <= (ff_gran_e'(gran_sel) == GRAN_LONG);
        end else if (run) begin
            pre_q  <= (pre_q == last) ? '0 : pre_q + 1'b1;
        end
    end

    // R4: the count never passes the terminal value of the latched length.
    p_pre_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= last);
    // R10: a restart clears the prescaler.
    p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0));
    // R4: the length is held between restarts.
    p_len_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(long_q));
endmodule

// File: rtl/ff_addr_seq.sv
// ff_addr_seq: table address sequencer and bank control.
// Assumes step comes from ff_step_timer and is only high while active is high.
// Keeps the running flag, the entry address, the played bank and the flag
// that a write is waiting to be swapped in.
module ff_addr_seq #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rf_gate,
    input  logic              pulse_start,
    input  logic              wr_en,
    input  logic              step,
    output logic              active,
    output logic [ADDR_W-1:0] addr,
    output logic              play_bank
);
    logic              active_q;
    logic [ADDR_W-1:0] addr_q;
    logic              bank_q;
    logic              pend_q;
    logic              accept;
    logic              at_last;

    assign accept  = rf_gate && pulse_start;
    assign at_last = &addr_q;

    // Running flag and address: gate closes, start restarts, step advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            addr_q   <= '0;
        end else if (!rf_gate) begin
            active_q <= 1'b0;
        end else if (pulse_start) begin
            active_q <= 1'b1;
            addr_q   <= '0;
        end else if (step) begin
            addr_q   <= addr_q + 1'b1;
            if (at_last) begin
                active_q <= 1'b0;
            end
        end
    end

    // Bank swap on an accepted start when a write has arrived since the last swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (accept) begin
            pend_q <= 1'b0;
            if (pend_q || wr_en) begin
                bank_q <= ~bank_q;
            end
        end else if (wr_en) begin
            pend_q <= 1'b1;
        end
    end

    assign active    = active_q;
    assign addr      = addr_q;
    assign play_bank = bank_q;

    // R10: an accepted start restarts at entry 0.
    p_start_clears_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (active_q && addr_q == '0));
    // R8: a closed gate stops playback.
    p_gate_low_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_gate |=> !active_q);
    // R9: a pending write plus a start swaps the banks.
    p_swap_on_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (pend_q || wr_en)) |=> (bank_q != $past(bank_q)));
    // R9: without an accepted start the played bank never changes.
    p_bank_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(bank_q));
    // R4: the address holds between steps.
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !step) |=> $stable(addr_q));
endmodule

// File: rtl/ff_playback.sv
// ff_playback: top of the feed-forward table player.
// Assumes the host rewrites the whole table between swaps and that pulse_start
// is a one-cycle strobe inside the RF gate. Output is registered alongside the
// table read, so entry 0 shows two edges after the accepting edge.
module ff_playback
    import ff_pkg::*;
#(
    parameter int unsigned ADDR_W  = FF_ADDR_W,
    parameter int unsigned IQ_W    = FF_IQ_W,
    parameter int unsigned OUT_W   = FF_OUT_W,
    parameter int unsigned SHORT_C = FF_SHORT_C,
    parameter int unsigned LONG_C  = FF_LONG_C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [IQ_W-1:0]   wr_i,
    input  logic [IQ_W-1:0]   wr_q,
    input  logic              rf_gate,
    input  logic              pulse_start,
    input  logic              ff_enable,
    input  logic              gran_sel,
    output logic [OUT_W-1:0]  ff_i,
    output logic [OUT_W-1:0]  ff_q
);
    localparam int unsigned EXT_W = OUT_W - IQ_W;

    logic              step;
    logic              active;
    logic [ADDR_W-1:0] addr;
    logic              play_bank;
    logic [IQ_W-1:0]   rd_val [2];
    logic [OUT_W-1:0]  ext_val [2];
    logic              valid_q;

    ff_step_timer #(.SHORT_C(SHORT_C), .LONG_C(LONG_C)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (rf_gate && pulse_start),
        .run      (active),
        .gran_sel (gran_sel),
        .step     (step)
    );

    ff_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rf_gate     (rf_gate),
        .pulse_start (pulse_start),
        .wr_en       (wr_en),
        .step        (step),
        .active      (active),
        .addr        (addr),
        .play_bank   (play_bank)
    );

    ff_iq_ram #(.ADDR_W(ADDR_W), .IQ_W(IQ_W)) u_ram (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_i      (wr_i),
        .wr_q      (wr_q),
        .play_bank (play_bank),
        .rd_addr   (addr),
        .rd_i      (rd_val[0]),
        .rd_q      (rd_val[1])
    );

    // Output qualifier, registered in step with the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= active && ff_enable && rf_gate;
        end
    end

    // Sign extension and zero gating, one copy per channel.
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        assign ext_val[ch] = valid_q
            ? {{EXT_W{rd_val[ch][IQ_W-1]}}, rd_val[ch]}
            : '0;
    end

    assign ff_i = ext_val[0];
    assign ff_q = ext_val[1];

    // R7: a disabled cycle gives zero on the next one.
    p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ff_enable |=> (ff_i == '0 && ff_q == '0));
    // R6: once playback is idle the outputs fall to zero.
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (ff_i == '0 && ff_q == '0));
    // R8: a closed gate gives zero on the next cycle.
    p_gate_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_gate |=> (ff_i == '0 && ff_q == '0));
endmodule

// File: tb/sim_ff_playback.sv
module sim_ff_playback;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_i = '0;
    logic [7:0]    wr_q = '0;
    logic          rf_gate = 1'b0;
    logic          pulse_start = 1'b0;
    logic          ff_enable = 1'b0;
    logic          gran_sel = 1'b0;
    logic [15:0]   ff_i;
    logic [15:0]   ff_q;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    bit    started = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    ff_playback #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_i(wr_i), .wr_q(wr_q), .rf_gate(rf_gate), .pulse_start(pulse_start),
        .ff_enable(ff_enable), .gran_sel(gran_sel), .ff_i(ff_i), .ff_q(ff_q)
    );

    function automatic logic [15:0] sx(input logic [7:0] v);
        return {{8{v[7]}}, v};
    endfunction
    function automatic logic [7:0] a_i(input int k);
        if (k == 0) return 8'h80;
        if (k == 1) return 8'hFF;
        return 8'(k * 37 + 11);
    endfunction
    function automatic logic [7:0] a_q(input int k);
        if (k == 0) return 8'h7F;
        if (k == 1) return 8'h01;
        return 8'(k * 53 + 200);
    endfunction
    function automatic logic [7:0] b_i(input int k);
        return 8'(k * 29 + 3) ^ 8'h55;
    endfunction
    function automatic logic [7:0] b_q(input int k);
        return 8'(255 - k * 7);
    endfunction

    // Behavioural model: two banks, swap flag, hold count, output register.
    logic [7:0]  mi [2][DEPTH];
    logic [7:0]  mq [2][DEPTH];
    int          m_act, m_addr, m_pre, m_len, m_bank, m_pend;
    logic [15:0] e_i = '0;
    logic [15:0] e_q = '0;

    always @(posedge clk) begin
        int  wb;
        bit  stp;
        cyc++;
        started = 1'b1;
        if (!rst_n) begin
            m_act = 0; m_addr = 0; m_pre = 0; m_len = 8; m_bank = 0; m_pend = 0;
            e_i = '0; e_q = '0;
        end else begin
            if (m_act != 0 && ff_enable && rf_gate) begin
                e_i = sx(mi[m_bank][m_addr]);
                e_q = sx(mq[m_bank][m_addr]);
            end else begin
                e_i = '0; e_q = '0;
            end
            stp = (m_act != 0) && (m_pre == m_len - 1);
            wb  = 1 - m_bank;
            if (wr_en) begin
                mi[wb][wr_addr] = wr_i;
                mq[wb][wr_addr] = wr_q;
            end
            if (rf_gate && pulse_start) begin
                if (m_pend != 0 || wr_en) m_bank = 1 - m_bank;
                m_pend = 0;
                m_pre  = 0;
                m_len  = gran_sel ? 16 : 8;
            end else begin
                if (wr_en) m_pend = 1;
                if (m_act != 0) m_pre = (m_pre == m_len - 1) ? 0 : m_pre + 1;
            end
            if (!rf_gate) begin
                m_act = 0;
            end else if (pulse_start) begin
                m_act = 1; m_addr = 0;
            end else if (stp) begin
                if (m_addr == DEPTH - 1) m_act = 0;
                m_addr = (m_addr + 1) % DEPTH;
            end
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            n_checks++;
            if (ff_i !== e_i || ff_q !== e_q) begin
                n_errors++;
                $display("FAIL %s cycle %0d: got i=%h q=%h expected i=%h q=%h",
                         cur_req, cyc, ff_i, ff_q, e_i, e_q);
            end
        end
    end

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_one(input int a, input logic [7:0] vi, input logic [7:0] vq);
        wr_en = 1'b1; wr_addr = AW'(a); wr_i = vi; wr_q = vq;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic start_pulse(input logic g);
        gran_sel = g; pulse_start = 1'b1;
        tick();
        pulse_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state.
        tick(4);
        chk("R1 i", ff_i, 16'h0000);
        chk("R1 q", ff_q, 16'h0000);
        rst_n = 1'b1;
        tick();

        // R2: load table A into bank 1; outputs stay zero.
        cur_req = "R2";
        for (int k = 0; k < DEPTH; k++) write_one(k, a_i(k), a_q(k));
        chk("R2 idle after writes", ff_i, 16'h0000);

        // R3/R4/R5/R6: short granularity pulse.
        cur_req = "R3";
        rf_gate = 1'b1; ff_enable = 1'b1;
        start_pulse(1'b0);
        tick();
        chk("R3 entry0 i / R5 sign", ff_i, 16'hFF80);
        chk("R5 entry0 q", ff_q, 16'h007F);
        tick(7);
        chk("R4 entry0 held 8", ff_i, 16'hFF80);
        tick();
        chk("R4 entry1 at 9", ff_i, 16'hFFFF);
        chk("R5 entry1 q", ff_q, 16'h0001);
        cur_req = "R6";
        tick(DEPTH * 8 - 9);
        chk("R6 last entry", ff_i, sx(a_i(DEPTH - 1)));
        tick();
        chk("R6 zero after end i", ff_i, 16'h0000);
        chk("R6 zero after end q", ff_q, 16'h0000);

        // R4/R9: long granularity replays bank A; table B written meanwhile.
        cur_req = "R9";
        start_pulse(1'b1);
        tick();
        chk("R9 replay entry0", ff_i, 16'hFF80);
        tick(15);
        chk("R4 entry0 held 16", ff_i, 16'hFF80);
        tick();
        chk("R4 entry1 at 17", ff_i, 16'hFFFF);
        for (int k = 0; k < DEPTH; k++) write_one(k, b_i(k), b_q(k));
        chk("R9 old table kept", ff_i, sx(a_i(3)));
        tick(DEPTH * 16);

        // R9/R7: next pulse plays B; enable toggled.
        start_pulse(1'b0);
        tick();
        chk("R9 new table entry0 i", ff_i, sx(b_i(0)));
        chk("R9 new table entry0 q", ff_q, sx(b_q(0)));
        cur_req = "R7";
        tick(5);
        ff_enable = 1'b0;
        tick();
        chk("R7 disabled zero", ff_i, 16'h0000);
        tick(13);
        ff_enable = 1'b1;
        tick();
        chk("R7 resume entry2", ff_i, sx(b_i(2)));

        // R8: gate drop stops playback; start ignored while gate low.
        cur_req = "R8";
        tick(10);
        rf_gate = 1'b0;
        tick();
        chk("R8 gate low zero", ff_i, 16'h0000);
        start_pulse(1'b0);
        tick(2);
        chk("R8 start ignored", ff_i, 16'h0000);
        rf_gate = 1'b1;
        tick(3);
        chk("R8 no resume", ff_q, 16'h0000);

        // R10: restart during playback.
        cur_req = "R10";
        start_pulse(1'b0);
        tick(50);
        start_pulse(1'b0);
        tick();
        chk("R10 restart entry0", ff_i, sx(b_i(0)));
        tick(8);
        chk("R10 fresh hold entry1", ff_i, sx(b_i(1)));
        tick(DEPTH * 8);

        // R11: write coinciding with start.
        cur_req = "R11";
        wr_en = 1'b1; wr_addr = '0; wr_i = 8'h5A; wr_q = 8'hA5;
        gran_sel = 1'b0; pulse_start = 1'b1;
        tick();
        wr_en = 1'b0; pulse_start = 1'b0;
        tick();
        chk("R11 same-cycle write i", ff_i, 16'h005A);
        chk("R11 same-cycle write q", ff_q, 16'hFFA5);
        tick(8);
        chk("R11 rest of bank", ff_i, 16'hFFFF);
        tick(DEPTH * 8);
        chk("R6 final idle", ff_i, 16'h0000);

        finish_run();
    end
endmodule